// File: doc/BRIEF.md
# Serial Register Slave with Selectable Bit Order

This block lets a host read and write a bank of 32 eight-bit registers over a four-wire serial link: a serial clock, an active-low select, a serial data input and a serial data output. The block runs on its own system clock. It brings the three link inputs across with synchronizer stages and detects the serial clock edges from the synchronized copy, so the serial clock must run several times slower than the system clock.

Each frame opens with an eight-bit command. The command gives the transfer direction, a byte count of one to four, and a five-bit start address. The data bytes follow straight after the command, with no idle bits in between. Bit 6 of register 0x00 chooses the bit order. When it is clear, the bits travel high bit first, and the byte address steps down after each data byte. When it is set, the bits travel low bit first, and the address steps up. Either way the address stops at the end of the bank and does not wrap. The bit order is captured while the select is high, so a change only applies from the next frame.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset every register holds 0x00, bit order is high-bit-first, and `serOut` is 0.
- R2: The command byte, in its natural bit positions, is: bit 7 direction (1 = read, 0 = write), bits 6:5 byte count minus one, bits 4:0 start address. `serIn` is sampled on rising `serClk` edges, and the first data bit follows the eighth command bit directly.
- R3: With register 0x00 bit 6 clear, command and data bits travel bit 7 first, and the byte address decreases by one after each data byte.
- R4: With register 0x00 bit 6 set, command and data bits travel bit 0 first, and the byte address increases by one after each data byte.
- R5: Read data changes on falling `serClk` edges. Bit one of the first byte appears on the falling edge after the eighth command bit. `serOut` is 0 whenever no read data phase is active, including the command phase and any write frame.
- R6: The byte address stops at 0x00 when stepping down and at 0x1F when stepping up. Further bytes in the frame then go to the same address.
- R7: Raising `selN` abandons the frame. A partially shifted byte is not written, and the next frame starts with a fresh command.
- R8: A write to register 0x00 bit 6 changes the bit order only from the next frame. The rest of the current frame keeps the old order.
- R9: Bytes clocked in after the commanded count are ignored: nothing is written, and `serOut` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial clock from the host |
| selN | input | 1 | Active-low frame select |
| serIn | input | 1 | Serial data from the host |
| serOut | output | 1 | Serial read data to the host |

## Verification
On every system clock, the assertions check four things: the frame state clears while the select is high, the latched bit order holds steady inside a frame, the byte address stops at both ends of the bank, and `serOut` is low outside a read data phase. Some behaviour shows only across whole frames. This covers the assembled value of each byte in both bit orders, the stepping direction of multibyte transfers, the late effect of a bit-order write, and the loss of abandoned partial bytes. The bench covers these with directed and seeded random frames, compared against a register model held in the bench.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  parameter int ADDR_W    = 5;
  parameter int DATA_W    = 8;
  parameter int CNT_W     = 2;
  parameter int ORDER_BIT = 6;
  localparam int NUM_REGS = 1 << ADDR_W;
  localparam int BIT_W    = $clog2(DATA_W);

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_DATA = 2'd1,
    PH_DONE = 2'd2
  } phase_t;

  typedef struct packed {
    logic              shiftEn;
    logic              lsbMode;
    logic              wrEn;
    logic [ADDR_W-1:0] wrAddr;
    logic              loadTx;
    logic [ADDR_W-1:0] loadAddr;
    logic              txShift;
    logic              rdActive;
  } dpStrobe_t;
endpackage

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_reg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              selN,
  input  logic              serIn,
  input  logic              lsbFirstCfg,
  input  logic [DATA_W-1:0] byteIn,
  output logic              sdiS,
  output dpStrobe_t         str
);
  localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(DATA_W - 1);
  localparam logic [ADDR_W-1:0] ADDR_MAX = {ADDR_W{1'b1}};
  localparam int RW_POS = DATA_W - 1;

  logic [SYNC_STAGES-1:0] sclkSync, csbSync, sdiSync;
  logic sclkS, csbS, sclkPrev;
  logic sclkRise, sclkFall, active;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      csbSync  <= '1;
      sdiSync  <= '0;
      sclkPrev <= 1'b0;
    end else begin
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], serClk};
      csbSync  <= {csbSync[SYNC_STAGES-2:0], selN};
      sdiSync  <= {sdiSync[SYNC_STAGES-2:0], serIn};
      sclkPrev <= sclkS;
    end
  end

  assign sclkS    = sclkSync[SYNC_STAGES-1];
  assign csbS     = csbSync[SYNC_STAGES-1];
  assign sdiS     = sdiSync[SYNC_STAGES-1];
  assign sclkRise = sclkS & ~sclkPrev;
  assign sclkFall = ~sclkS & sclkPrev;
  assign active   = ~csbS;

  phase_t            phase;
  logic [BIT_W-1:0]  bitCnt;
  logic [CNT_W-1:0]  byteCnt, lastByte;
  logic              isRead, lsbMode;
  logic [ADDR_W-1:0] addr, nextAddr;
  logic              byteDone;

  assign byteDone = active && sclkRise && (phase != PH_DONE) && (bitCnt == LAST_BIT);

  always_comb begin
    if (lsbMode) nextAddr = (addr == ADDR_MAX) ? addr : addr + 1'b1;
    else         nextAddr = (addr == '0) ? addr : addr - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_CMD;
      bitCnt   <= '0;
      byteCnt  <= '0;
      lastByte <= '0;
      isRead   <= 1'b0;
      lsbMode  <= 1'b0;
      addr     <= '0;
    end else if (!active) begin
      phase   <= PH_CMD;
      bitCnt  <= '0;
      byteCnt <= '0;
      isRead  <= 1'b0;
      lsbMode <= lsbFirstCfg;
    end else if (sclkRise && phase != PH_DONE) begin
      bitCnt <= bitCnt + 1'b1;
      if (bitCnt == LAST_BIT) begin
        if (phase == PH_CMD) begin
          isRead   <= byteIn[RW_POS];
          lastByte <= byteIn[ADDR_W+CNT_W-1:ADDR_W];
          addr     <= byteIn[ADDR_W-1:0];
          byteCnt  <= '0;
          phase    <= PH_DATA;
        end else begin
          addr    <= nextAddr;
          byteCnt <= byteCnt + 1'b1;
          if (byteCnt == lastByte) phase <= PH_DONE;
        end
      end
    end
  end

  always_comb begin
    str          = '0;
    str.lsbMode  = lsbMode;
    str.shiftEn  = active && sclkRise && (phase != PH_DONE);
    str.wrEn     = byteDone && (phase == PH_DATA) && !isRead;
    str.wrAddr   = addr;
    str.loadTx   = byteDone && (((phase == PH_CMD) && byteIn[RW_POS]) ||
                                ((phase == PH_DATA) && isRead && (byteCnt != lastByte)));
    str.loadAddr = (phase == PH_CMD) ? byteIn[ADDR_W-1:0] : nextAddr;
    str.txShift  = active && sclkFall && (phase == PH_DATA) && isRead;
    str.rdActive = active && isRead && (phase == PH_DATA);
  end

  // R7: select high returns the frame state to the command start
  assert_frame_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> (bitCnt == '0 && phase == PH_CMD && byteCnt == '0));

  // R8: bit order never changes inside a frame
  assert_order_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (active && $past(active)) |-> $stable(lsbMode));

  // R6: stepping down stops at the bottom of the bank
  assert_addr_floor_R6: assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && phase == PH_DATA && !lsbMode && addr == '0) |=> (addr == '0));

  // R6: stepping up stops at the top of the bank
  assert_addr_ceil_R6: assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && phase == PH_DATA && lsbMode && addr == ADDR_MAX) |=> (addr == ADDR_MAX));

  // R9: no write once the commanded byte count is used up
  assert_no_extra_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DONE) |-> !str.wrEn);
endmodule

// File: rtl/spi_reg_dp.sv
module spi_reg_dp
  import spi_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdiS,
  input  dpStrobe_t         str,
  output logic [DATA_W-1:0] byteIn,
  output logic              lsbFirstCfg,
  output logic              serOut
);
  logic [DATA_W-1:0] shReg;
  logic [DATA_W-1:0] txReg;
  logic [DATA_W-1:0] regs [NUM_REGS];

  // Both orders land each bit at its natural position once the byte is complete
  assign byteIn = str.lsbMode ? {sdiS, shReg[DATA_W-1:1]} : {shReg[DATA_W-2:0], sdiS};
  assign lsbFirstCfg = regs[0][ORDER_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shReg <= '0;
    else if (str.shiftEn) shReg <= byteIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (str.wrEn) begin
      regs[str.wrAddr] <= byteIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg  <= '0;
      serOut <= 1'b0;
    end else begin
      if (str.loadTx) begin
        txReg <= regs[str.loadAddr];
      end else if (str.txShift) begin
        txReg <= str.lsbMode ? {1'b0, txReg[DATA_W-1:1]} : {txReg[DATA_W-2:0], 1'b0};
      end
      if (!str.rdActive)    serOut <= 1'b0;
      else if (str.txShift) serOut <= str.lsbMode ? txReg[0] : txReg[DATA_W-1];
    end
  end

  // R5: output is quiet one cycle after any cycle with no read data phase
  assert_out_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    !str.rdActive |=> !serOut);

  // R5: output only moves on a falling-edge launch or when a read ends
  assert_out_launch_R5: assert property (@(posedge clk) disable iff (!rstN)
    (str.rdActive && !str.txShift) |=> $stable(serOut));
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic serClk,
  input  logic selN,
  input  logic serIn,
  output logic serOut
);
  dpStrobe_t         str;
  logic              sdiS;
  logic              lsbFirstCfg;
  logic [DATA_W-1:0] byteIn;

  spi_reg_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .serClk(serClk), .selN(selN), .serIn(serIn),
    .lsbFirstCfg(lsbFirstCfg), .byteIn(byteIn), .sdiS(sdiS), .str(str)
  );

  spi_reg_dp u_dp (
    .clk(clk), .rstN(rstN), .sdiS(sdiS), .str(str),
    .byteIn(byteIn), .lsbFirstCfg(lsbFirstCfg), .serOut(serOut)
  );
endmodule

// File: tb/spi_reg_slave_bench.sv
module spi_reg_slave_bench;
  localparam int HALF = 6;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, selN = 1'b1, serIn = 1'b0;
  logic serOut;
  int checks = 0, fails = 0;
  logic [7:0] model [32];
  logic [7:0] txb [5];
  logic lsbModel = 1'b0;

  always #10 clk = ~clk;

  spi_reg_slave u_spi_reg_slave (
    .clk(clk), .rstN(rstN), .serClk(serClk), .selN(selN), .serIn(serIn), .serOut(serOut)
  );

  task automatic clkWait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] stepAddr(input logic [4:0] a, input logic up);
    if (up) return (a == 5'h1F) ? a : a + 5'd1;
    return (a == 5'h00) ? a : a - 5'd1;
  endfunction

  task automatic shiftByte(input logic [7:0] b, input int nbits, output logic [7:0] r);
    r = '0;
    for (int i = 0; i < nbits; i++) begin
      int idx;
      idx = lsbModel ? i : 7 - i;
      serIn = b[idx];
      clkWait(HALF);
      r[idx] = serOut;
      serClk = 1'b1;
      clkWait(HALF);
      serClk = 1'b0;
    end
  endtask

  // rd: read; nb: commanded count; sendBytes: full bytes clocked; tailBits: partial bits then abort
  task automatic runFrame(input logic rd, input int nb, input logic [4:0] a,
                          input int sendBytes, input int tailBits, input string tag);
    logic [7:0] rx;
    logic [7:0] cmd;
    logic [4:0] ad;
    string t;
    cmd = {rd, 2'(nb - 1), a};
    t = (tag != "") ? tag : (lsbModel ? "R4" : "R3");
    selN = 1'b0;
    clkWait(HALF);
    shiftByte(cmd, 8, rx);
    check("R5 idle in command", rx, 8'h00);
    ad = a;
    for (int k = 0; k < sendBytes; k++) begin
      shiftByte(txb[k], 8, rx);
      if (k < nb) begin
        if (rd) check(t, rx, model[ad]);
        else begin
          model[ad] = txb[k];
          check("R5 quiet in write", rx, 8'h00);
        end
        ad = stepAddr(ad, lsbModel);
      end else begin
        check("R9 extra byte quiet", rx, 8'h00);
      end
    end
    if (tailBits > 0) shiftByte(txb[4], tailBits, rx);
    clkWait(HALF);
    selN = 1'b1;
    clkWait(3 * HALF);
    lsbModel = model[0][6];
  endtask

  task automatic setTx(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                       input logic [7:0] d, input logic [7:0] e);
    txb[0] = a; txb[1] = b; txb[2] = c; txb[3] = d; txb[4] = e;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    void'($urandom(32'h5EED_1234));
    clkWait(5);
    rstN = 1'b1;
    clkWait(4);
    check("R1 output after reset", {7'd0, serOut}, 8'h00);
    setTx(0, 0, 0, 0, 0);
    runFrame(1'b1, 4, 5'h03, 4, 0, "R1 reset register value");

    // R3 / R2: high-bit-first 4-byte write stepping down, then read back
    setTx(8'hA5, 8'h3C, 8'h81, 8'h7E, 8'h00);
    runFrame(1'b0, 4, 5'h05, 4, 0, "");
    runFrame(1'b1, 4, 5'h05, 4, 0, "R3 descending read");
    runFrame(1'b1, 1, 5'h03, 1, 0, "R2 single byte read");

    // R6: bottom stop while stepping down
    setTx(8'h11, 8'h22, 8'h13, 8'h00, 8'h00);
    runFrame(1'b0, 3, 5'h01, 3, 0, "");
    runFrame(1'b1, 1, 5'h00, 1, 0, "R6 floor holds last byte");
    runFrame(1'b1, 1, 5'h01, 1, 0, "R6 floor first byte");

    // R8: order bit set by first byte, second byte still high-bit-first
    setTx(8'h40, 8'h41, 8'h00, 8'h00, 8'h00);
    runFrame(1'b0, 2, 5'h00, 2, 0, "");
    runFrame(1'b1, 1, 5'h00, 1, 0, "R8 order change deferred");

    // R4 / R6: low-bit-first ascending write with top stop
    setTx(8'hC3, 8'h5A, 8'h96, 8'h0F, 8'h00);
    runFrame(1'b0, 4, 5'h1D, 4, 0, "");
    runFrame(1'b1, 3, 5'h1D, 3, 0, "R4 ascending read");
    runFrame(1'b1, 1, 5'h1F, 1, 0, "R6 ceiling holds last byte");

    // R7: abort mid-byte, partial byte dropped
    setTx(8'hE7, 8'h00, 8'h00, 8'h00, 8'hFF);
    runFrame(1'b0, 2, 5'h10, 1, 5, "");
    runFrame(1'b1, 2, 5'h10, 2, 0, "R7 partial byte dropped");

    // R9: extra bytes in write and read frames
    setTx(8'h99, 8'h77, 8'h66, 8'h00, 8'h00);
    runFrame(1'b0, 1, 5'h08, 3, 0, "");
    runFrame(1'b1, 3, 5'h08, 3, 0, "R9 neighbours untouched");
    runFrame(1'b1, 1, 5'h08, 3, 0, "R9 read with extra bytes");

    // back to high-bit-first (low-bit-first frame writing register 0)
    setTx(8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    runFrame(1'b0, 1, 5'h00, 1, 0, "");
    runFrame(1'b1, 2, 5'h06, 2, 0, "R3 order restored");

    // seeded random frames
    for (int n = 0; n < 80; n++) begin
      logic rd;
      int nb, sb, tb;
      logic [4:0] a;
      rd = 1'($urandom % 2);
      nb = 1 + int'($urandom % 4);
      a  = 5'($urandom % 32);
      sb = nb + (($urandom % 4 == 0) ? 1 : 0);
      tb = ($urandom % 6 == 0) ? 1 + int'($urandom % 7) : 0;
      setTx(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
      runFrame(rd, nb, a, sb, tb, "");
    end
    for (int i = 0; i < 32; i += 4) runFrame(1'b1, 4, 5'(i + (lsbModel ? 0 : 3)), 4, 0, "R2 final sweep");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule